// File: doc/BRIEF.md
# Triangle PWM Timer with Linked Sawtooth Counter

This block generates the carrier for center-aligned multi-phase PWM. A W-bit carrier counter climbs from zero to a programmed cycle value M, then turns and descends from M+1 back to one, so one full period lasts 2M+2 clocks. A second W-bit counter only ever counts up. When it is linked to the carrier (the tune bit is set), it restarts from zero at the start of each half of the triangle. It therefore matches the carrier on every rising half and forms a fresh ramp 0..M on every falling half. Two compare registers on the sawtooth counter raise one-cycle hit pulses, and these can be routed to A/D conversion trigger outputs.

Software programs the block through a simple write port. Address 0 is the carrier control register; its bit 0 is the carrier run bit. Address 1 is the sawtooth control register: bit 0 run, bit 1 tune, bit 2 trigger enable for compare A, bit 3 trigger enable for compare B. Address 2 holds the cycle value, address 3 compare A and address 4 compare B. Linked operation starts by setting the sawtooth run bit (with tune) and then the carrier run bit. It stops by clearing the carrier run bit, then the sawtooth run bit, then the tune bit. When the tune bit is clear, the sawtooth counter is a free timer that wraps at compare A, and its hits never reach the trigger outputs.

Top module: `tri_pwm_timer`

## Requirements
- R1: After reset both counters read 0, the direction flag reads up and neither counter runs. A write of 1 to carrier bit 0 while the carrier is stopped clears both counters to 0 and sets the direction to up on that clock edge.
- R2: While running, the carrier steps each clock through 0,1,..,M (direction up) and then M+1,M,..,1 (direction down, carrier_down=1), and repeats with period 2M+2.
- R3: When linked, the sawtooth counter runs only while the carrier runs. It counts 0..M during each half of the triangle, so it equals the carrier on every rising half.
- R4: peak_pulse is high exactly in the running cycle where the carrier holds M+1 going down. valley_pulse is high exactly in the running cycle where it holds 1 going down.
- R5: cmp_hit[0] (compare A) and cmp_hit[1] (compare B) are high exactly when the sawtooth counter runs and equals the active compare value.
- R6: adc_trig[i] equals cmp_hit[i] when the tune bit and trigger-enable bit i (sawtooth control bit 2 for A, bit 3 for B) are set; otherwise it stays 0.
- R7: While the carrier runs, writes to the sawtooth control register are ignored, and a write of 1 to carrier bit 0 does not restart it. Only a write that clears carrier bit 0 takes effect.
- R8: A write that would change the tune bit is ignored while either run bit is set.
- R9: With the tune bit clear, the sawtooth counter runs on its own run bit alone, wraps from compare A to 0, and takes compare writes from the next clock.
- R10: While the carrier runs linked, new cycle and compare values wait in buffers and become active at the edge where the carrier goes from 1 back to 0.
- R11: Clearing the carrier run bit lets that edge complete its step, then freezes the carrier and the linked sawtooth counter and silences both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 carrier ctl, 1 sawtooth ctl, 2 cycle, 3 compare A, 4 compare B) |
| wr_data | input | W | Write data |
| carrier_cnt | output | W | Triangle counter value |
| carrier_down | output | 1 | High while the triangle descends |
| peak_pulse | output | 1 | One-cycle pulse at the top turnaround |
| valley_pulse | output | 1 | One-cycle pulse at the last count of the descent |
| carrier_run | output | 1 | Carrier run bit |
| saw_cnt | output | W | Sawtooth counter value |
| saw_run | output | 1 | High while the sawtooth counter advances |
| cmp_hit | output | 2 | Compare hit pulses (bit 0 A, bit 1 B) |
| adc_trig | output | 2 | A/D trigger pulses (bit 0 A, bit 1 B) |

## Verification
The bench sweeps several cycle values, including M=0, where the peak and valley pulses coincide and the sawtooth never leaves zero. A design with a wrong turnaround would show a period other than 2M+2 or a count off by one at the top. The bench changes the cycle value and compare A mid-period and expects the old values until the return to zero. A design that applied writes at once would hit at the wrong place or cut the triangle short. Writes that try to restart, reconfigure or untune a running block must leave the counts unchanged. An untuned sawtooth counter must wrap at compare A with its triggers silent, because a design that leaked the link state would fire triggers or follow the carrier.

// File: rtl/tpt_pkg.sv
package tpt_pkg;

    localparam int NCMP = 2;
    localparam int AW   = 3;

    typedef enum logic [AW-1:0] {
        A_CARRIER_CTL = 3'd0,
        A_SAW_CTL     = 3'd1,
        A_CYCLE       = 3'd2,
        A_CMP_A       = 3'd3,
        A_CMP_B       = 3'd4
    } reg_addr_e;

    // bit 0 run, bit 1 tune, bit 2 trigger A enable, bit 3 trigger B enable
    typedef struct packed {
        logic trg_b;
        logic trg_a;
        logic tune;
        logic run;
    } saw_ctl_t;

    function automatic logic addr_hit(input logic we, input logic [AW-1:0] a, input int sel);
        return we && (a == AW'(sel));
    endfunction

endpackage

// File: rtl/tpt_regs.sv
module tpt_regs
    import tpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [W-1:0]              wr_data,
    input  logic                      valley,
    output logic                      c_run,
    output saw_ctl_t                  sctl,
    output logic                      c_start,
    output logic                      s_start,
    output logic [W-1:0]              cyc_act,
    output logic [NCMP-1:0][W-1:0]    cmp_act
);

    logic           wr_c, wr_s, wr_cyc, reload;
    logic [W-1:0]   cyc_buf;

    always_comb begin
        wr_c    = addr_hit(wr_en, wr_addr, int'(A_CARRIER_CTL));
        wr_s    = addr_hit(wr_en, wr_addr, int'(A_SAW_CTL));
        wr_cyc  = addr_hit(wr_en, wr_addr, int'(A_CYCLE));
        c_start = wr_c && wr_data[0] && !c_run;
        s_start = c_start || (wr_s && wr_data[0] && !c_run && !sctl.run);
        reload  = !c_run || valley;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_run   <= 1'b0;
            sctl    <= '0;
            cyc_buf <= '0;
            cyc_act <= '0;
        end else begin
            if (wr_c)
                c_run <= wr_data[0];
            if (wr_s && !c_run) begin
                sctl.run   <= wr_data[0];
                sctl.trg_a <= wr_data[2];
                sctl.trg_b <= wr_data[3];
                if (!sctl.run)
                    sctl.tune <= wr_data[1];
            end
            if (wr_cyc)
                cyc_buf <= wr_data;
            if (reload)
                cyc_act <= cyc_buf;
        end
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp_reg
        logic         wr_i;
        logic [W-1:0] pend, act;
        assign wr_i       = addr_hit(wr_en, wr_addr, int'(A_CMP_A) + i);
        assign cmp_act[i] = act;
        always_ff @(posedge clk) begin
            if (rst) begin
                pend <= '0;
                act  <= '0;
            end else begin
                if (wr_i)
                    pend <= wr_data;
                if (!sctl.tune) begin
                    if (wr_i)
                        act <= wr_data;
                end else if (reload) begin
                    act <= pend;
                end
            end
        end
    end

    // R7: sawtooth control is locked while the carrier runs
    assert_saw_ctl_locked_R7: assert property (@(posedge clk) disable iff (rst)
        c_run |=> sctl == $past(sctl));

    // R8: tune bit frozen while anything runs
    assert_tune_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (c_run || sctl.run) |=> sctl.tune == $past(sctl.tune));

endmodule

// File: rtl/tpt_carrier.sv
module tpt_carrier #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         start,
    input  logic [W-1:0] cyc,
    output logic [W-1:0] cnt,
    output logic         down,
    output logic         peak,
    output logic         valley
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W:0] cyc_p1;

    always_comb begin
        cyc_p1 = {1'b0, cyc} + {{W{1'b0}}, 1'b1};
        peak   = run && down && ({1'b0, cnt} == cyc_p1);
        valley = run && down && (cnt == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (run) begin
            if (!down) begin
                cnt <= cnt + ONE;
                if (cnt == cyc)
                    down <= 1'b1;
            end else begin
                cnt <= cnt - ONE;
                if (cnt == ONE)
                    down <= 1'b0;
            end
        end
    end

    // R2: a running carrier changes value every clock
    assert_carrier_moves_R2: assert property (@(posedge clk) disable iff (rst)
        run |=> cnt != $past(cnt));

    // R2: never above the turnaround value
    assert_carrier_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run |-> {1'b0, cnt} <= cyc_p1);

    // R11: a stopped carrier holds still
    assert_carrier_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(cnt));

endmodule

// File: rtl/tpt_saw.sv
module tpt_saw #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == lim) ? '0 : cnt + W'(1);
    end

    // R3: the ramp restarts from zero after reaching its limit
    assert_saw_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == lim) |=> cnt == '0);

    // R11: a stopped sawtooth holds still
    assert_saw_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(cnt));

endmodule

// File: rtl/tpt_cmp.sv
module tpt_cmp
    import tpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                   run,
    input  logic                   tune,
    input  logic [W-1:0]           cnt,
    input  logic [NCMP-1:0][W-1:0] cmp_act,
    input  logic [NCMP-1:0]        trg_en,
    output logic [NCMP-1:0]        hit,
    output logic [NCMP-1:0]        trig
);

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign hit[i]  = run && (cnt == cmp_act[i]);
        assign trig[i] = hit[i] && tune && trg_en[i];
    end

endmodule

// File: rtl/tri_pwm_timer.sv
module tri_pwm_timer
    import tpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      carrier_cnt,
    output logic              carrier_down,
    output logic              peak_pulse,
    output logic              valley_pulse,
    output logic              carrier_run,
    output logic [W-1:0]      saw_cnt,
    output logic              saw_run,
    output logic [NCMP-1:0]   cmp_hit,
    output logic [NCMP-1:0]   adc_trig
);

    saw_ctl_t                 sctl;
    logic                     c_start, s_start;
    logic [W-1:0]             cyc_act, saw_lim;
    logic [NCMP-1:0][W-1:0]   cmp_act;

    tpt_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .valley  (valley_pulse),
        .c_run   (carrier_run),
        .sctl    (sctl),
        .c_start (c_start),
        .s_start (s_start),
        .cyc_act (cyc_act),
        .cmp_act (cmp_act)
    );

    tpt_carrier #(.W(W)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .run    (carrier_run),
        .start  (c_start),
        .cyc    (cyc_act),
        .cnt    (carrier_cnt),
        .down   (carrier_down),
        .peak   (peak_pulse),
        .valley (valley_pulse)
    );

    always_comb begin
        saw_run = sctl.run && (sctl.tune ? carrier_run : 1'b1);
        saw_lim = sctl.tune ? cyc_act : cmp_act[0];
    end

    tpt_saw #(.W(W)) u_saw (
        .clk (clk),
        .rst (rst),
        .run (saw_run),
        .clr (s_start),
        .lim (saw_lim),
        .cnt (saw_cnt)
    );

    tpt_cmp #(.W(W)) u_cmp (
        .run     (saw_run),
        .tune    (sctl.tune),
        .cnt     (saw_cnt),
        .cmp_act (cmp_act),
        .trg_en  ({sctl.trg_b, sctl.trg_a}),
        .hit     (cmp_hit),
        .trig    (adc_trig)
    );

    // R3: linked sawtooth equals the carrier on every rising half
    assert_linked_track_R3: assert property (@(posedge clk) disable iff (rst)
        (saw_run && sctl.tune && !carrier_down) |-> saw_cnt == carrier_cnt);

    // R4: peak only while descending
    assert_peak_down_R4: assert property (@(posedge clk) disable iff (rst)
        peak_pulse |-> carrier_down && carrier_run);

endmodule

// File: tb/tb_tri_pwm_timer.sv
module tb_tri_pwm_timer;
    import tpt_pkg::*;

    localparam int W = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [W-1:0]    wr_data = '0;
    logic [W-1:0]    carrier_cnt, saw_cnt;
    logic            carrier_down, peak_pulse, valley_pulse, carrier_run, saw_run;
    logic [NCMP-1:0] cmp_hit, adc_trig;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    tri_pwm_timer #(.W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .carrier_cnt(carrier_cnt), .carrier_down(carrier_down),
        .peak_pulse(peak_pulse), .valley_pulse(valley_pulse),
        .carrier_run(carrier_run), .saw_cnt(saw_cnt), .saw_run(saw_run),
        .cmp_hit(cmp_hit), .adc_trig(adc_trig)
    );

    always #5 clk = ~clk;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // caller stands at a negedge; the write lands on the next posedge
    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = a[AW-1:0];
        wr_data = d[W-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic void tri_at(input int k, input int m,
                                   output int mc, output int sc, output bit dn, output int p);
        p = k % (2 * m + 2);
        if (p <= m) begin
            mc = p; sc = p; dn = 1'b0;
        end else begin
            mc = 2 * m + 2 - p; sc = p - m - 1; dn = 1'b1;
        end
    endfunction

    task automatic check_carrier(input int k, input int m);
        int mc, sc, p; bit dn;
        tri_at(k, m, mc, sc, dn, p);
        chk("R2 carrier count", carrier_cnt, mc);
        chk("R2 carrier direction", carrier_down, dn);
        chk("R4 peak pulse", peak_pulse, p == m + 1);
        chk("R4 valley pulse", valley_pulse, p == 2 * m + 1);
    endtask

    task automatic check_linked(input int k, input int m, input int ca, input int cb,
                                input bit ea, input bit eb);
        int mc, sc, p; bit dn;
        tri_at(k, m, mc, sc, dn, p);
        check_carrier(k, m);
        chk("R3 sawtooth count", saw_cnt, sc);
        if (!dn) chk("R3 equal on rising half", saw_cnt, carrier_cnt);
        chk("R5 hit A", cmp_hit[0], sc == ca);
        chk("R5 hit B", cmp_hit[1], sc == cb);
        chk("R6 trigger A", adc_trig[0], ea && sc == ca);
        chk("R6 trigger B", adc_trig[1], eb && sc == cb);
    endtask

    task automatic stop_linked();
        wr(0, 0);
        wr(1, 0);
        wr(1, 0);
    endtask

    task automatic run_linked(input int m, input int ca, input int cb, input bit ea, input bit eb);
        int n, mc, sc, p; bit dn;
        wr(2, m); wr(3, ca); wr(4, cb);
        wr(1, 3 | (int'(ea) << 2) | (int'(eb) << 3));
        wr(0, 1);
        chk("R1 start clears carrier", carrier_cnt, 0);
        chk("R1 start clears sawtooth", saw_cnt, 0);
        n = 3 * (2 * m + 2) + 1;
        for (int k = 0; k < n; k++) begin
            check_linked(k, m, ca, cb, ea, eb);
            @(negedge clk);
        end
        wr(0, 0);
        tri_at(n + 1, m, mc, sc, dn, p);
        chk("R11 carrier frozen after stop", carrier_cnt, mc);
        repeat (3) @(negedge clk);
        chk("R11 carrier still frozen", carrier_cnt, mc);
        chk("R11 sawtooth frozen", saw_cnt, sc);
        chk("R11 no peak when stopped", peak_pulse, 0);
        chk("R11 no valley when stopped", valley_pulse, 0);
        wr(1, 0); wr(1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset carrier", carrier_cnt, 0);
        chk("R1 reset sawtooth", saw_cnt, 0);
        chk("R1 reset direction", carrier_down, 0);
        chk("R1 reset carrier idle", carrier_run, 0);
        chk("R1 reset sawtooth idle", saw_run, 0);
        chk("R6 reset triggers", adc_trig, 0);

        // linked sweep over small cycle values
        run_linked(0, 0, 0, 1'b1, 1'b0);
        run_linked(1, 1, 0, 1'b1, 1'b1);
        run_linked(2, 2, 1, 1'b0, 1'b1);
        run_linked(3, 1, 3, 1'b1, 1'b1);
        run_linked(5, 4, 7, 1'b1, 1'b1);
        run_linked(7, 0, 6, 1'b1, 1'b0);

        // R7: protection while the carrier runs
        begin
            int mc, sc, p; bit dn;
            wr(2, 4); wr(3, 2); wr(4, 0); wr(1, 15); wr(0, 1);
            repeat (3) @(negedge clk);
            wr(0, 1);
            chk("R7 no restart on rewrite", carrier_cnt, 4);
            check_linked(4, 4, 2, 0, 1'b1, 1'b1);
            wr(1, 0);
            chk("R7 sawtooth run kept", saw_run, 1);
            check_linked(5, 4, 2, 0, 1'b1, 1'b1);
            wr(1, 1);
            for (int k = 6; k < 13; k++) begin
                check_linked(k, 4, 2, 0, 1'b1, 1'b1);
                @(negedge clk);
            end
            wr(0, 0);
            tri_at(14, 4, mc, sc, dn, p);
            chk("R11 stop lands on next step", carrier_cnt, mc);
            chk("R11 sawtooth idle after stop", saw_run, 0);
            chk("R7 stop write honoured", carrier_run, 0);
            wr(1, 0); wr(1, 0);
        end

        // R8 and R9: free-running sawtooth, tune attempt ignored
        wr(2, 6); wr(3, 3); wr(4, 1);
        wr(1, 1);
        chk("R9 sawtooth runs alone", saw_run, 1);
        chk("R9 carrier still idle", carrier_run, 0);
        repeat (3) @(negedge clk);
        chk("R9 free count", saw_cnt, 3);
        wr(1, 15);
        wr(0, 1);
        for (int k = 0; k < 20; k++) begin
            check_carrier(k, 6);
            chk("R9 wraps at compare A", saw_cnt, k % 4);
            chk("R5 hit A untuned", cmp_hit[0], (k % 4) == 3);
            chk("R5 hit B untuned", cmp_hit[1], (k % 4) == 1);
            chk("R8 tune ignored, R6 triggers silent", adc_trig, 0);
            @(negedge clk);
        end
        wr(3, 1);
        for (int k = 21; k < 29; k++) begin
            chk("R9 compare applied at once", saw_cnt, k % 2);
            chk("R9 hit A new value", cmp_hit[0], (k % 2) == 1);
            chk("R6 triggers silent", adc_trig, 0);
            @(negedge clk);
        end
        wr(0, 0);
        chk("R9 sawtooth keeps running", saw_run, 1);
        wr(1, 0);
        chk("R9 sawtooth stopped", saw_run, 0);

        // R10: buffered reload at the valley
        wr(2, 3); wr(3, 1); wr(4, 9); wr(1, 7); wr(0, 1);
        for (int k = 0; k < 24; k++) begin
            if (k < 8) check_linked(k, 3, 1, 9, 1'b1, 1'b0);
            else       check_linked(k - 8, 5, 4, 9, 1'b1, 1'b0);
            if (k == 8) chk("R10 new cycle active after valley", carrier_cnt, 0);
            wr_en = (k == 2) || (k == 3);
            wr_addr = (k == 2) ? AW'(2) : AW'(3);
            wr_data = (k == 2) ? W'(5) : W'(4);
            @(negedge clk);
            wr_en = 1'b0;
        end
        stop_linked();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule